// File: doc/BRIEF.md
# Programmable Millisecond One-Shot Timer

A one-shot timer whose pulse length is set in milliseconds. A rising edge on the write strobe stores a 16-bit interval. After that, a rising edge on the read strobe pulls the active-high status output low for the stored number of milliseconds. The output then returns high.

The pulse cannot be retriggered. Read edges that arrive while it runs are dropped, so the first edge fixes when the period ends. A millisecond is counted as `TICK_CYCLES` clock cycles. The default of 32000 suits a 32 MHz clock, so a stored value of 3000 gives three seconds low.

A global enable freezes every register while it is low. A synchronous clear and an active-low asynchronous reset both return the block to idle, with no interval stored.

Top module: `ms_oneshot_timer`

## Requirements
- R1: After `rst_ni` is low, or one cycle after `srst_i` is high, the status output is high and no interval is stored.
- R2: While no period is running, the status output stays high.
- R3: A rising edge on `wr_i` with `en_i` high stores `interval_i` as the interval that the next period uses.
- R4: A rising edge on `rd_i` sampled at a clock edge starts a period when all of the following hold: `en_i` is high, the block is idle and a nonzero interval is stored. The status output is then low from that edge for exactly interval × `TICK_CYCLES` cycles, and high again after them.
- R5: Rising edges on `rd_i` while a period runs neither restart nor lengthen it.
- R6: A read edge before any interval has been stored has no effect, and the output stays high.
- R7: Only rising edges count. Holding `rd_i` high past the end of a period starts no second period.
- R8: A stored interval of zero produces no low pulse.
- R9: A write during a running period changes neither the length nor the end of that period. The new value applies to the next period.
- R10: While `en_i` is low, no register changes. A running period is held for those cycles, and a write while disabled stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear to idle |
| en_i | input | 1 | Global enable for all state updates |
| wr_i | input | 1 | Interval write strobe (rising edge) |
| interval_i | input | INTERVAL_W | Interval in milliseconds |
| rd_i | input | 1 | Start strobe (rising edge) |
| status_o | output | 1 | High when idle, low during a period |

## Verification
A table of intervals (1, 2, 3, 5, 10 and zero) measures the low time of each single pulse. This separates a correct multiply by the tick length from off-by-one errors in the prescaler or the counter, and shows the zero case. Directed runs then vary the timing of the inputs:
- Repeated read edges inside a period separate a non-retriggerable timer from one that restarts.
- A read strobe held high past the end of a period separates edge detection from level sensing.
- A write in mid-period separates a latched counter from one that reloads live.
- A disabled window inside a period shows that the prescaler and the counter both freeze.
- A synchronous clear, and a read with nothing stored, show that the load flag gates the start.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  localparam int unsigned STRB_WR = 0;
  localparam int unsigned STRB_RD = 1;
  localparam int unsigned NUM_STRB = 2;
endpackage

// File: rtl/oneshot_edge.sv
module oneshot_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         en_i,
  input  logic [N-1:0] strb_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_strb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     prev_q[g] <= 1'b0;
      else if (srst_i) prev_q[g] <= 1'b0;
      else if (en_i)   prev_q[g] <= strb_i[g];
    end
    assign rise_o[g] = strb_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/oneshot_prescaler.sv
module oneshot_prescaler #(
  parameter int unsigned TICK_CYCLES = 32000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic en_i,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] CNT_MAX = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CNT_MAX);
  assign tick_o = en_i & run_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (srst_i)  cnt_q <= '0;
    else if (en_i) begin
      if (clear_i)    cnt_q <= '0;
      else if (run_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/oneshot_core.sv
module oneshot_core
  import oneshot_pkg::*;
#(
  parameter int unsigned INTERVAL_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  srst_i,
  input  logic                  en_i,
  input  logic                  wr_rise_i,
  input  logic [INTERVAL_W-1:0] interval_i,
  input  logic                  rd_rise_i,
  input  logic                  tick_i,
  output logic                  start_o,
  output logic                  busy_o
);
  run_state_e            state_q;
  logic [INTERVAL_W-1:0] intv_q;
  logic [INTERVAL_W-1:0] remain_q;
  logic                  loaded_q;

  // start uses the interval held before any same-cycle write
  assign start_o = en_i & ~srst_i & (state_q == ST_IDLE) & rd_rise_i
                 & loaded_q & (intv_q != '0);
  assign busy_o  = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      intv_q   <= '0;
      remain_q <= '0;
      loaded_q <= 1'b0;
    end else if (srst_i) begin
      state_q  <= ST_IDLE;
      intv_q   <= '0;
      remain_q <= '0;
      loaded_q <= 1'b0;
    end else if (en_i) begin
      if (wr_rise_i) begin
        intv_q   <= interval_i;
        loaded_q <= 1'b1;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (start_o) begin
            state_q  <= ST_RUN;
            remain_q <= intv_q;
          end
        end
        ST_RUN: begin
          if (tick_i) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == INTERVAL_W'(1)) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ms_oneshot_timer.sv
module ms_oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned INTERVAL_W  = 16,
  parameter int unsigned TICK_CYCLES = 32000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  srst_i,
  input  logic                  en_i,
  input  logic                  wr_i,
  input  logic [INTERVAL_W-1:0] interval_i,
  input  logic                  rd_i,
  output logic                  status_o
);
  logic [NUM_STRB-1:0] strb;
  logic [NUM_STRB-1:0] rise;
  logic                start;
  logic                busy;
  logic                tick;

  assign strb[STRB_WR] = wr_i;
  assign strb[STRB_RD] = rd_i;

  oneshot_edge #(.N(NUM_STRB)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst_i),
    .en_i   (en_i),
    .strb_i (strb),
    .rise_o (rise)
  );

  oneshot_prescaler #(.TICK_CYCLES(TICK_CYCLES)) i_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst_i),
    .en_i    (en_i),
    .clear_i (start),
    .run_i   (busy),
    .tick_o  (tick)
  );

  oneshot_core #(.INTERVAL_W(INTERVAL_W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst_i),
    .en_i       (en_i),
    .wr_rise_i  (rise[STRB_WR]),
    .interval_i (interval_i),
    .rd_rise_i  (rise[STRB_RD]),
    .tick_i     (tick),
    .start_o    (start),
    .busy_o     (busy)
  );

  assign status_o = ~busy;
endmodule

// File: rtl/ms_oneshot_timer_chk.sv
module ms_oneshot_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic srst_i,
  input logic en_i,
  input logic rd_i,
  input logic status_o
);
  AST_CLEAR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> status_o); // R1

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !srst_i) |=> $stable(status_o)); // R10

  AST_FALL_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o) |-> $past(rd_i && en_i && !srst_i)); // R4

  AST_HELD_READ_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_i) && $past(en_i) && rd_i && status_o) |=> status_o); // R7
endmodule

bind ms_oneshot_timer ms_oneshot_timer_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .srst_i   (srst_i),
  .en_i     (en_i),
  .rd_i     (rd_i),
  .status_o (status_o)
);

// File: tb/test_ms_oneshot_timer.sv
module test_ms_oneshot_timer;
  localparam int TICK = 4;
  localparam int IW   = 16;
  localparam int NV   = 6;
  localparam int VEC_IV  [NV] = '{1, 3, 5, 0, 10, 2};
  localparam int VEC_EXP [NV] = '{4, 12, 20, 0, 40, 8};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic srst_i = 1'b0;
  logic en_i = 1'b1;
  logic wr_i = 1'b0;
  logic [IW-1:0] interval_i = '0;
  logic rd_i = 1'b0;
  logic status_o;

  int n_chk = 0;
  int n_err = 0;
  int low;

  always #4 clk = ~clk;

  ms_oneshot_timer #(.INTERVAL_W(IW), .TICK_CYCLES(TICK)) i_ms_oneshot_timer (
    .clk_i(clk), .rst_ni(rst_ni), .srst_i(srst_i), .en_i(en_i),
    .wr_i(wr_i), .interval_i(interval_i), .rd_i(rd_i), .status_o(status_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_iv(input int v);
    @(negedge clk);
    interval_i = IW'(v);
    wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  // read edge, then count low cycles; optional extra reads, a write and a disabled window
  task automatic run_pulse(input int rd_a, input int rd_b, input int wr_at, input int wr_val,
                           input int dis_at, input int dis_len, output int cnt);
    @(negedge clk);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    cnt = 0;
    while (status_o == 1'b0 && cnt < 1000) begin
      rd_i = (cnt == rd_a) || (cnt == rd_b);
      wr_i = (cnt == wr_at);
      if (cnt == wr_at) interval_i = IW'(wr_val);
      en_i = !(cnt >= dis_at && cnt < dis_at + dis_len);
      cnt++;
      @(negedge clk);
    end
    rd_i = 1'b0;
    wr_i = 1'b0;
    en_i = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic stays_high(input int n, input string req);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!status_o) lows++;
    end
    check(lows == 0, req, lows, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(status_o == 1'b1, "R1 reset", status_o, 1);
    rst_ni = 1'b1;

    // R6: read with nothing stored
    @(negedge clk); rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
    stays_high(20, "R6 read before write");
    check(status_o == 1'b1, "R2 idle high", status_o, 1);

    // R3 R4 R8: table walk
    for (int k = 0; k < NV; k++) begin
      write_iv(VEC_IV[k]);
      run_pulse(-1, -1, -1, 0, -1, 0, low);
      check(low == VEC_EXP[k], (VEC_IV[k] == 0) ? "R8 zero interval" : "R4 pulse length",
            low, VEC_EXP[k]);
    end

    // R5: extra read edges mid-period
    write_iv(10);
    run_pulse(10, 20, -1, 0, -1, 0, low);
    check(low == 40, "R5 no retrigger", low, 40);

    // R7: read held high through and past the period
    write_iv(3);
    @(negedge clk); rd_i = 1'b1;
    @(negedge clk);
    low = 0;
    while (status_o == 1'b0 && low < 1000) begin low++; @(negedge clk); end
    check(low == 12, "R7 held read length", low, 12);
    stays_high(30, "R7 held read no restart");
    rd_i = 1'b0;
    @(negedge clk);

    // R9: write mid-period
    write_iv(2);
    run_pulse(-1, -1, 2, 5, -1, 0, low);
    check(low == 8, "R9 current period kept", low, 8);
    run_pulse(-1, -1, -1, 0, -1, 0, low);
    check(low == 20, "R9 new value next period", low, 20);

    // R10: disabled window pauses period
    write_iv(3);
    run_pulse(-1, -1, -1, 0, 4, 7, low);
    check(low == 19, "R10 pause extends", low, 19);

    // R10: write while disabled stores nothing
    @(negedge clk); en_i = 1'b0; interval_i = IW'(9); wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
    @(negedge clk); en_i = 1'b1;
    run_pulse(-1, -1, -1, 0, -1, 0, low);
    check(low == 12, "R10 disabled write ignored", low, 12);

    // R1: sync clear mid-period, then nothing stored
    write_iv(5);
    @(negedge clk); rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
    check(status_o == 1'b0, "R4 period started", status_o, 0);
    @(negedge clk); srst_i = 1'b1;
    @(negedge clk); srst_i = 1'b0;
    check(status_o == 1'b1, "R1 sync clear", status_o, 1);
    @(negedge clk); rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
    stays_high(20, "R1 clear drops interval");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule